// File: doc/BRIEF.md
# Time-Ordered Response Scheduler Queue

This block sits on the return path of a memory target. Every accepted response gets a due time: the current cycle count plus a per-request receive delay, a fixed base latency and a random extra latency. The response is then held in a small sorted queue until that time has come. The queue is kept in due-time order. An entry never moves in front of an older entry with the same address, so responses to one location leave in the order they arrived.

Only the head entry is offered on the response channel. If the receiver refuses it, the block waits for a retry pulse and offers the same entry again. A drain request makes the block report whether responses are still pending or the queue has emptied. When the queue is full, the acceptor upstream must stall.

Top module: `resp_sched_q`

## Requirements
- R1: A response accepted in the cycle where the internal time is T, with receive delay D and the extra latency at zero, has due time T + D + BASE_LAT. `out_valid` first rises for it in the cycle where time equals that due time. Time is 0 in the first cycle after reset and then counts up by one each cycle.
- R2: The extra latency lies between 0 and the value on `lat_var`, both included. A `lat_var` of 0 adds nothing.
- R3: A new entry is placed by scanning back from the tail. It passes an entry only while its own due time is strictly earlier and the addresses differ. It never passes the head. Same-address entries therefore keep their arrival order.
- R4: Only the head is offered, and never before its due time. `out_addr` and `out_data` carry the head's fields.
- R5: When `out_valid` is high and `out_ready` is low, the head stays in the queue and `out_valid` goes low. It stays low until a pulse on `out_retry`, and the same entry is offered in the cycle after that pulse.
- R6: An offer accepted with `out_ready` high removes the head. The next entry is offered in the very next cycle if its due time has already passed, and otherwise at its due time. This also holds when a new entry is inserted in the same cycle.
- R7: `full` is high when DEPTH entries are held. A request presented while `full` is high is dropped and never appears on the output.
- R8: With `drain_req` high, `draining` is high while entries remain and `drained` is high once the queue is empty. With `drain_req` low, both are low.
- R9: After reset the queue is empty, and `out_valid`, `full` and `draining` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Response to be scheduled this cycle |
| in_addr | input | AW | Address of the response |
| in_data | input | DW | Response payload |
| in_delay | input | DLW | Receive delay in cycles |
| lat_var | input | VW | Upper bound of the random extra latency |
| full | output | 1 | Queue holds DEPTH entries; stall requests |
| out_valid | output | 1 | Head response offered |
| out_ready | input | 1 | Receiver takes the offered response |
| out_retry | input | 1 | Receiver asks for a refused response again |
| out_addr | output | AW | Address of the head response |
| out_data | output | DW | Payload of the head response |
| drain_req | input | 1 | Drain requested |
| draining | output | 1 | Drain requested, entries remain |
| drained | output | 1 | Drain requested, queue empty |

## Verification
The tests use several insertion patterns, and each one separates a different ordering rule. A back-to-back burst of mixed delays and addresses shows three things at once: a shorter due time overtakes a longer one at a different address, it stops behind a same-address entry with a later due time, and it never displaces a late head. A lone entry with a known delay pins the exact release cycle. A pair offered into a stalled receiver separates "wait for the retry pulse" from "resend as soon as ready". A pop and an insert in the same cycle, a fill to full followed by a drain, and repeated single entries with a nonzero variance cover the remaining corners.

// File: rtl/resp_sched_pkg.sv
`timescale 1ns/1ps
package resp_sched_pkg;

  // response channel states
  typedef enum logic {
    TX_READY = 1'b0,
    TX_WAIT  = 1'b1
  } tx_state_e;

  // extra-latency pseudo random source
  localparam int          LFSR_W    = 16;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam logic [15:0] LFSR_TAPS = 16'hB400;

endpackage

// File: rtl/resp_lat_gen.sv
`timescale 1ns/1ps
module resp_lat_gen
  import resp_sched_pkg::*;
#(
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] var_i,
  output logic [VW-1:0] extra_o
);

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_d;

  // Galois step, advanced every cycle
  always_comb begin
    lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]};
    if (lfsr_q[0]) begin
      lfsr_d = lfsr_d ^ LFSR_TAPS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_SEED;
    end else begin
      lfsr_q <= lfsr_d;
    end
  end

  // masking by the bound keeps the term within 0..var_i
  assign extra_o = lfsr_q[VW-1:0] & var_i;

endmodule

// File: rtl/resp_sched_store.sv
`timescale 1ns/1ps
module resp_sched_store #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int TW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ins,
  input  logic [AW-1:0]               ins_addr,
  input  logic [DW-1:0]               ins_data,
  input  logic [TW-1:0]               ins_due,
  input  logic                        pop,
  output logic [AW-1:0]               head_addr,
  output logic [DW-1:0]               head_data,
  output logic [TW-1:0]               head_due,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        full,
  output logic                        empty
);

  localparam int CW = $clog2(DEPTH+1);
  localparam int IW = $clog2(DEPTH);

  logic [TW-1:0] due_q  [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [TW-1:0] due_d  [DEPTH];
  logic [AW-1:0] addr_d [DEPTH];
  logic [DW-1:0] data_d [DEPTH];
  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic [CW-1:0] pos;
  logic [DEPTH-1:0] pass;
  logic          upd;

  // an entry may be passed by the newcomer (slot 0 is the head, never passed)
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_pass
      if (g == 0) begin : g_head
        assign pass[g] = 1'b0;
      end else begin : g_body
        assign pass[g] = (CW'(g) < count_q) && (ins_due < due_q[g]) &&
                         (addr_q[g] != ins_addr);
      end
    end
  endgenerate

  // backward scan from the tail, stopping at the first entry not passed
  always_comb begin
    pos = count_q;
    for (int i = DEPTH-1; i >= 1; i--) begin
      if ((CW'(i + 1) == pos) && pass[i]) begin
        pos = CW'(i);
      end
    end
  end

  // next contents: shift out the head on pop, open a slot on insert
  always_comb begin
    int ppos;
    int popn;
    int src;
    popn = pop ? 1 : 0;
    ppos = int'(pos) - popn;
    for (int j = 0; j < DEPTH; j++) begin
      src = (ins && (j > ppos)) ? (j - 1 + popn) : (j + popn);
      if (src >= DEPTH) begin
        src = j;
      end
      if (ins && (j == ppos)) begin
        due_d[j]  = ins_due;
        addr_d[j] = ins_addr;
        data_d[j] = ins_data;
      end else begin
        due_d[j]  = due_q[IW'(src)];
        addr_d[j] = addr_q[IW'(src)];
        data_d[j] = data_q[IW'(src)];
      end
    end
  end

  assign upd     = ins | pop;
  assign count_d = count_q + CW'(ins) - CW'(pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (upd) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      due_q  <= due_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign head_due  = due_q[0];
  assign head_addr = addr_q[0];
  assign head_data = data_q[0];
  assign count     = count_q;
  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);

endmodule

// File: rtl/resp_tx_ctrl.sv
`timescale 1ns/1ps
module resp_tx_ctrl
  import resp_sched_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_ok,
  input  logic [TW-1:0] head_due,
  input  logic [TW-1:0] now,
  input  logic          out_ready,
  input  logic          out_retry,
  input  logic          drain_req,
  output logic          out_valid,
  output logic          pop,
  output logic          draining,
  output logic          drained
);

  tx_state_e state_q;
  tx_state_e state_d;
  logic      due_hit;

  assign due_hit   = head_ok && (head_due <= now);
  assign out_valid = due_hit && (state_q == TX_READY);
  assign pop       = out_valid && out_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_READY: if (out_valid && !out_ready) state_d = TX_WAIT;
      TX_WAIT:  if (out_retry)               state_d = TX_READY;
      default:                               state_d = TX_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_READY;
    end else begin
      state_q <= state_d;
    end
  end

  assign draining = drain_req && head_ok;
  assign drained  = drain_req && !head_ok;

endmodule

// File: rtl/resp_sched_q.sv
`timescale 1ns/1ps
module resp_sched_q #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int DLW      = 6,
  parameter int VW       = 4,
  parameter int TW       = 32,
  parameter int DEPTH    = 8,
  parameter int BASE_LAT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [AW-1:0]  in_addr,
  input  logic [DW-1:0]  in_data,
  input  logic [DLW-1:0] in_delay,
  input  logic [VW-1:0]  lat_var,
  output logic           full,
  output logic           out_valid,
  input  logic           out_ready,
  input  logic           out_retry,
  output logic [AW-1:0]  out_addr,
  output logic [DW-1:0]  out_data,
  input  logic           drain_req,
  output logic           draining,
  output logic           drained
);

  localparam int CW = $clog2(DEPTH+1);

  logic [TW-1:0] now_q;
  logic [TW-1:0] now_d;
  logic [VW-1:0] extra;
  logic [TW-1:0] due;
  logic          in_accept;
  logic          pop;
  logic          empty;
  logic [TW-1:0] head_due;
  logic [CW-1:0] count;

  // free-running time base
  assign now_d = now_q + TW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
    end else begin
      now_q <= now_d;
    end
  end

  resp_lat_gen #(.VW(VW)) u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .var_i   (lat_var),
    .extra_o (extra)
  );

  assign due       = now_q + TW'(in_delay) + TW'(BASE_LAT) + TW'(extra);
  assign in_accept = in_valid && !full;

  resp_sched_store #(
    .AW(AW), .DW(DW), .TW(TW), .DEPTH(DEPTH)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins       (in_accept),
    .ins_addr  (in_addr),
    .ins_data  (in_data),
    .ins_due   (due),
    .pop       (pop),
    .head_addr (out_addr),
    .head_data (out_data),
    .head_due  (head_due),
    .count     (count),
    .full      (full),
    .empty     (empty)
  );

  resp_tx_ctrl #(.TW(TW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_ok   (!empty),
    .head_due  (head_due),
    .now       (now_q),
    .out_ready (out_ready),
    .out_retry (out_retry),
    .drain_req (drain_req),
    .out_valid (out_valid),
    .pop       (pop),
    .draining  (draining),
    .drained   (drained)
  );

endmodule

// File: rtl/resp_sched_q_chk.sv
`timescale 1ns/1ps
module resp_sched_q_chk #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int TW = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_accept,
  input logic          full,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [DW-1:0] out_data,
  input logic          drain_req,
  input logic          draining,
  input logic          drained,
  input logic [TW-1:0] now,
  input logic [TW-1:0] head_due,
  input logic [CW-1:0] count
);

  // R1
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (now == $past(now) + TW'(1)));

  // R4
  not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (head_due <= now));

  // R5
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (!out_valid && $stable(out_data) && $stable(out_addr)));

  // R6
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_accept) |=> (count == $past(count) - CW'(1)));

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !(out_valid && out_ready)) |=> full);

  // R8
  drained_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> (!out_valid && !draining));

  // R8
  no_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_req |-> (!draining && !drained));

endmodule

bind resp_sched_q resp_sched_q_chk #(
  .AW(AW), .DW(DW), .TW(TW), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_accept (in_accept),
  .full      (full),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_data  (out_data),
  .drain_req (drain_req),
  .draining  (draining),
  .drained   (drained),
  .now       (now_q),
  .head_due  (head_due),
  .count     (count)
);

// File: tb/test_resp_sched_q.sv
`timescale 1ns/1ps
module test_resp_sched_q;

  localparam int AW = 8, DW = 16, DLW = 6, VW = 4, TW = 32, DEPTH = 8, BASE = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [AW-1:0]  in_addr;
  logic [DW-1:0]  in_data;
  logic [DLW-1:0] in_delay;
  logic [VW-1:0]  lat_var;
  logic           full, out_valid, out_ready, out_retry;
  logic [AW-1:0]  out_addr;
  logic [DW-1:0]  out_data;
  logic           drain_req, draining, drained;

  int  checks = 0;
  int  errors = 0;
  longint tc;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  resp_sched_q #(
    .AW(AW), .DW(DW), .DLW(DLW), .VW(VW), .TW(TW), .DEPTH(DEPTH), .BASE_LAT(BASE)
  ) i_resp_sched_q (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_data(in_data), .in_delay(in_delay), .lat_var(lat_var), .full(full),
    .out_valid(out_valid), .out_ready(out_ready), .out_retry(out_retry),
    .out_addr(out_addr), .out_data(out_data), .drain_req(drain_req),
    .draining(draining), .drained(drained)
  );

  // bench time mirror: 0 in the first cycle after reset
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc <= 0;
    else        tc <= tc + 1;
  end

  typedef struct packed { logic [7:0] addr; logic [15:0] data; logic [5:0] dly; } vin_t;
  typedef struct packed { logic [15:0] data; logic [7:0] rel; } vout_t;

  // burst inserted on consecutive cycles (R3)
  localparam vin_t VIN [5] = '{
    '{8'd1, 16'hA000, 6'd20},
    '{8'd2, 16'hA001, 6'd12},
    '{8'd3, 16'hA002, 6'd2},
    '{8'd2, 16'hA003, 6'd0},
    '{8'd5, 16'hA004, 6'd5}
  };
  // expected release order and cycle relative to the first insert
  localparam vout_t VOUT [5] = '{
    '{16'hA000, 8'd24},
    '{16'hA002, 8'd25},
    '{16'hA001, 8'd26},
    '{16'hA003, 8'd27},
    '{16'hA004, 8'd28}
  };

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DLW-1:0] dl);
    in_valid = 1'b1; in_addr = a; in_data = d; in_delay = dl;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_tc(input longint t);
    while (tc < t) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint t0;
    int n;
    logic [DW-1:0] got [DEPTH];
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_data = '0; in_delay = '0;
    lat_var = '0; out_ready = 1'b1; out_retry = 1'b0; drain_req = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "out_valid in reset", out_valid, 0);
    chk("R9", "full in reset", full, 0);
    chk("R9", "draining in reset", draining, 0);
    rst_n = 1'b1;
    @(negedge clk);
    drain_req = 1'b1; #1;
    chk("R8", "drained when empty", drained, 1);
    chk("R8", "draining when empty", draining, 0);
    drain_req = 1'b0; #1;
    chk("R8", "drained without request", drained, 0);

    // R1 exact release cycle: delay 3 -> due T+7
    t0 = tc;
    push(8'd9, 16'h1111, 6'd3);
    wait_tc(t0 + 6);
    chk("R1", "valid one cycle early", out_valid, 0);
    @(negedge clk);
    chk("R1", "valid at due", out_valid, 1);
    chk("R4", "head data", out_data, 16'h1111);
    chk("R4", "head addr", out_addr, 8'd9);
    @(negedge clk);
    chk("R6", "queue empty after accept", out_valid, 0);

    // R3 table of insertions, walked by one loop
    t0 = tc;
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b1; in_addr = VIN[k].addr; in_data = VIN[k].data; in_delay = VIN[k].dly;
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_tc(t0 + 23);
    chk("R3", "late head not overtaken", out_valid, 0);
    for (int k = 0; k < 5; k++) begin
      wait_tc(t0 + longint'(VOUT[k].rel));
      chk("R3", "release valid", out_valid, 1);
      chk("R3", "release order", out_data, VOUT[k].data);
    end
    @(negedge clk);
    chk("R6", "table emptied", out_valid, 0);

    // R5 refusal and retry
    out_ready = 1'b0;
    t0 = tc;
    push(8'd1, 16'hB000, 6'd0);
    push(8'd2, 16'hB001, 6'd0);
    wait_tc(t0 + 4);
    chk("R5", "offered before refusal", out_valid, 1);
    @(negedge clk);
    chk("R5", "quiet after refusal", out_valid, 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R5", "no resend without retry", out_valid, 0);
    chk("R5", "head kept", out_data, 16'hB000);
    out_retry = 1'b1;
    @(negedge clk);
    out_retry = 1'b0;
    chk("R5", "resend after retry", out_valid, 1);
    chk("R5", "same entry resent", out_data, 16'hB000);
    @(negedge clk);
    chk("R6", "overdue next head at once", out_valid, 1);
    chk("R6", "next head data", out_data, 16'hB001);
    @(negedge clk);
    chk("R6", "empty after pair", out_valid, 0);

    // R6 pop and insert in the same cycle
    t0 = tc;
    push(8'd4, 16'hD000, 6'd0);
    wait_tc(t0 + 4);
    chk("R6", "first at due", out_data, 16'hD000);
    push(8'd4, 16'hD001, 6'd0);
    chk("R6", "popped while inserting", out_valid, 0);
    wait_tc(t0 + 7);
    chk("R6", "inserted not early", out_valid, 0);
    @(negedge clk);
    chk("R6", "inserted at due", out_data, 16'hD001);
    chk("R6", "inserted valid", out_valid, 1);
    @(negedge clk);

    // R7 fill to full, extra request dropped; R8 drain
    for (int k = 0; k < DEPTH; k++) push(AW'(k), DW'(16'hC000 + k), 6'd40);
    chk("R7", "full at depth", full, 1);
    push(8'd7, 16'hCFFF, 6'd0);
    chk("R7", "still full after dropped request", full, 1);
    drain_req = 1'b1; #1;
    chk("R8", "draining with entries", draining, 1);
    chk("R8", "not drained with entries", drained, 0);
    n = 0;
    for (int c = 0; c < 100 && n < DEPTH; c++) begin
      @(negedge clk);
      if (out_valid) begin
        got[n] = out_data;
        n++;
      end
    end
    chk("R8", "draining on last entry", draining, 1);
    chk("R8", "not drained on last entry", drained, 0);
    @(negedge clk);
    chk("R8", "drained after last", drained, 1);
    chk("R8", "draining cleared", draining, 0);
    chk("R7", "entries released", n, DEPTH);
    for (int k = 0; k < DEPTH; k++) chk("R7", "release kept", got[k], 16'hC000 + k);
    drain_req = 1'b0;
    @(negedge clk);
    chk("R7", "dropped request absent", out_valid, 0);

    // R2 random extra latency bounded by lat_var
    lat_var = 4'd3;
    for (int k = 0; k < 8; k++) begin
      t0 = tc;
      push(8'd6, DW'(16'hE000 + k), 6'd0);
      for (int c = 0; c < 20 && !out_valid; c++) @(negedge clk);
      chk("R2", "latency within bound", ((tc - t0) >= BASE) && ((tc - t0) <= BASE + 3), 1);
      @(negedge clk);
    end
    lat_var = '0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule